// File: doc/BRIEF.md
# Banked GPIO Pin Array with Packed Configuration Bytes

This block owns a parameterised set of general-purpose pins and exposes them to software as rows of configuration bytes on a Wishbone-style register bus. Each pin has one byte, and a bus word holds one byte per data lane. Row 0 therefore covers the first DATA_W/8 pins, row 1 the next group, and so on. A write replaces every byte of the addressed row, so software keeps its own shadow copy of the row.

The byte also carries a bank number. In bank 0 the stored byte drives the pad directly. In banks 1 to 3 an attached peripheral port drives output, output enable and input enable, and it receives the pad input. Pull-up and pull-down always stay under the register's control. Bank numbers 4 to 7 park the pin: the driver and receiver are off and no peripheral sees the input.

Bus handling is a two-state machine. S_IDLE accepts a request (cyc and stb high) and moves to S_ACK. S_ACK raises the acknowledge for one cycle and always returns to S_IDLE.

Top module: `gpio_bank_array`

## Requirements
- R1: After reset every byte is zero. All pad_oe, pad_ie, pad_pu, pad_pd and pad_o outputs are low, and a read of a row returns only the synchronised input bits.
- R2: Byte layout is bit 0 output enable, bit 1 input enable, bit 2 pull-up, bit 3 pull-down, bit 4 data, bits 7:5 bank. Rows are addressed in words. Pin r*(DATA_W/8)+k sits in byte k (bits 8k+7:8k) of row r.
- R3: In bank 0, pad_o follows the stored data bit, pad_oe the output enable and pad_ie the input enable.
- R4: In bank b (1 to 3), pad_o, pad_oe and pad_ie come from peripheral port b at index (b-1)*NUM_PINS+pin. per_i of that port carries pad_i, per_i of the other ports is low, and the pulls still come from the byte.
- R5: A written byte with bit 0 clear leaves the stored data bit unchanged.
- R6: On read, the data bit returns the stored output when output enable is set. When output enable is clear, it returns pad_i through a two-flop synchroniser, which is visible three cycles after pad_i changes.
- R7: Rows at or beyond ceil(NUM_PINS/(DATA_W/8)) read as zero and ignore writes.
- R8: wb_ack rises in the cycle after a request is accepted and lasts one cycle. Read data is valid while wb_ack is high.
- R9: Bank numbers 4 to 7 force pad_o, pad_oe and pad_ie low and give no peripheral the input. The pulls still follow the byte.
- R10: A write replaces all pin bytes of the addressed row at once and leaves other rows untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | ADDR_W | Row address in words |
| wb_dat_w | input | DATA_W | Write data |
| wb_dat_r | output | DATA_W | Read data |
| wb_ack | output | 1 | Acknowledge |
| pad_i | input | NUM_PINS | Pad input |
| pad_o | output | NUM_PINS | Pad output |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_ie | output | NUM_PINS | Pad input enable |
| pad_pu | output | NUM_PINS | Pull-up enable |
| pad_pd | output | NUM_PINS | Pull-down enable |
| per_o | input | 3*NUM_PINS | Peripheral output, banks 1..3 |
| per_oe | input | 3*NUM_PINS | Peripheral output enable |
| per_ie | input | 3*NUM_PINS | Peripheral input enable |
| per_i | output | 3*NUM_PINS | Pad input routed to the owning peripheral |

## Verification
Bytes of different values are written into different lanes of one row. This shows whether each field lands on the right pad and whether lanes are swapped. Rewriting a row with a sparse pattern separates a true whole-row replacement from a merge, and writing the data bit with output enable clear separates ignored writes from stored ones. One pin is moved through banks 0, 1, 3 and 5 while the peripheral ports hold different levels, which shows which port owns the pin. A write to an unpopulated row is followed by a read and a check of the pads, so a decode that aliases onto real pins is caught.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PERIPH_BANKS = 3;

    typedef struct packed {
        logic [2:0] bank;
        logic       io;
        logic       pd;
        logic       pu;
        logic       ie;
        logic       oe;
    } pin_cfg_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } bus_state_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc,
    input  logic stb,
    output logic accept,
    output logic ack
);
    bus_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        ack      = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cyc && stb) begin
                    accept   = 1'b1;
                    state_nx = S_ACK;
                end
            end
            S_ACK: begin
                ack      = 1'b1;
                state_nx = S_IDLE;
            end
        endcase
    end

    // R8: acknowledge follows acceptance by one cycle
    a_r8_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ack);
    // R8: acknowledge is a single-cycle pulse
    a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

// File: rtl/gpio_pin_route.sv
module gpio_pin_route
    import gpio_bank_pkg::*;
(
    input  pin_cfg_t                cfg,
    input  logic                    pad_i,
    input  logic [PERIPH_BANKS-1:0] per_o,
    input  logic [PERIPH_BANKS-1:0] per_oe,
    input  logic [PERIPH_BANKS-1:0] per_ie,
    output logic [PERIPH_BANKS-1:0] per_i,
    output logic                    pad_o,
    output logic                    pad_oe,
    output logic                    pad_ie,
    output logic                    pad_pu,
    output logic                    pad_pd
);
    always_comb begin
        pad_pu = cfg.pu;
        pad_pd = cfg.pd;
        pad_o  = 1'b0;
        pad_oe = 1'b0;
        pad_ie = 1'b0;
        per_i  = '0;
        if (cfg.bank == 3'd0) begin
            pad_o  = cfg.io;
            pad_oe = cfg.oe;
            pad_ie = cfg.ie;
        end else begin
            for (int b = 0; b < PERIPH_BANKS; b++) begin
                if (cfg.bank == 3'(b + 1)) begin
                    pad_o    = per_o[b];
                    pad_oe   = per_oe[b];
                    pad_ie   = per_ie[b];
                    per_i[b] = pad_i;
                end
            end
        end
    end
endmodule

// File: rtl/gpio_bank_array.sv
module gpio_bank_array
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wb_cyc,
    input  logic                           wb_stb,
    input  logic                           wb_we,
    input  logic [ADDR_W-1:0]              wb_adr,
    input  logic [DATA_W-1:0]              wb_dat_w,
    output logic [DATA_W-1:0]              wb_dat_r,
    output logic                           wb_ack,
    input  logic [NUM_PINS-1:0]            pad_i,
    output logic [NUM_PINS-1:0]            pad_o,
    output logic [NUM_PINS-1:0]            pad_oe,
    output logic [NUM_PINS-1:0]            pad_ie,
    output logic [NUM_PINS-1:0]            pad_pu,
    output logic [NUM_PINS-1:0]            pad_pd,
    input  logic [3*NUM_PINS-1:0]          per_o,
    input  logic [3*NUM_PINS-1:0]          per_oe,
    input  logic [3*NUM_PINS-1:0]          per_ie,
    output logic [3*NUM_PINS-1:0]          per_i
);
    localparam int PPR  = DATA_W / 8;
    localparam int ROWS = (NUM_PINS + PPR - 1) / PPR;

    logic                  accept;
    logic [NUM_PINS-1:0]   pad_i_s;
    pin_cfg_t              cfg_q  [NUM_PINS];
    pin_cfg_t              rd_byte[NUM_PINS];
    logic [NUM_PINS*8-1:0] cfg_flat;
    logic [DATA_W-1:0]     rd_word;

    gpio_bus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc    (wb_cyc),
        .stb    (wb_stb),
        .accept (accept),
        .ack    (wb_ack)
    );

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_i),
        .q     (pad_i_s)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int ROW  = p / PPR;
        localparam int LANE = p % PPR;
        pin_cfg_t wr_new, wr_byte;
        logic     row_sel;

        assign row_sel = (wb_adr == ADDR_W'(ROW));
        assign wr_new  = pin_cfg_t'(wb_dat_w[LANE*8 +: 8]);

        always_comb begin
            wr_byte = wr_new;
            if (!wr_new.oe) wr_byte.io = cfg_q[p].io;
            rd_byte[p] = cfg_q[p];
            if (!cfg_q[p].oe) rd_byte[p].io = pad_i_s[p];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            cfg_q[p] <= '0;
            else if (accept && wb_we && row_sel)   cfg_q[p] <= wr_byte;
        end

        assign cfg_flat[p*8 +: 8] = cfg_q[p];

        gpio_pin_route u_route (
            .cfg    (cfg_q[p]),
            .pad_i  (pad_i[p]),
            .per_o  ({per_o[2*NUM_PINS+p],  per_o[NUM_PINS+p],  per_o[p]}),
            .per_oe ({per_oe[2*NUM_PINS+p], per_oe[NUM_PINS+p], per_oe[p]}),
            .per_ie ({per_ie[2*NUM_PINS+p], per_ie[NUM_PINS+p], per_ie[p]}),
            .per_i  ({per_i[2*NUM_PINS+p],  per_i[NUM_PINS+p],  per_i[p]}),
            .pad_o  (pad_o[p]),
            .pad_oe (pad_oe[p]),
            .pad_ie (pad_ie[p]),
            .pad_pu (pad_pu[p]),
            .pad_pd (pad_pd[p])
        );

        // R5: a write with output enable clear keeps the stored data bit
        a_r5_io_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && wb_we && row_sel && !wb_dat_w[LANE*8])
            |=> (cfg_q[p].io == $past(cfg_q[p].io)));
    end

    always_comb begin
        rd_word = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (wb_adr == ADDR_W'(p / PPR)) rd_word[(p % PPR)*8 +: 8] = rd_byte[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 wb_dat_r <= '0;
        else if (accept && !wb_we)  wb_dat_r <= rd_word;
    end

    // R7: a write to an unpopulated row changes no pin byte
    a_r7_oor_write: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wb_we && ({1'b0, wb_adr} >= (ADDR_W+1)'(ROWS)))
        |=> $stable(cfg_flat));
endmodule

// File: tb/gpio_bank_array_tb.sv
`timescale 1ns/1ps
module gpio_bank_array_tb;
    localparam int N  = 16;
    localparam int DW = 32;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
    logic [AW-1:0] wb_adr = '0;
    logic [DW-1:0] wb_dat_w = '0;
    logic [DW-1:0] wb_dat_r;
    logic wb_ack;
    logic [N-1:0] pad_i = '0;
    logic [N-1:0] pad_o, pad_oe, pad_ie, pad_pu, pad_pd;
    logic [3*N-1:0] per_o = '0, per_oe = '0, per_ie = '0;
    logic [3*N-1:0] per_i;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_bank_array #(.NUM_PINS(N), .DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
        .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .pad_ie(pad_ie),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .per_o(per_o), .per_oe(per_oe),
        .per_ie(per_ie), .per_i(per_i)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus(input bit we, input logic [AW-1:0] adr, input logic [DW-1:0] wd, output logic [DW-1:0] rd);
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = adr; wb_dat_w = wd;
        @(posedge clk);
        @(negedge clk);
        check(wb_ack === 1'b1, "R8 ack after accept", wb_ack, 1);
        rd = wb_dat_r;
        wb_cyc = 0; wb_stb = 0; wb_we = 0;
        @(negedge clk);
        check(wb_ack === 1'b0, "R8 ack one cycle", wb_ack, 0);
    endtask

    task automatic wr(input logic [AW-1:0] adr, input logic [DW-1:0] wd);
        logic [DW-1:0] dummy;
        bus(1'b1, adr, wd, dummy);
    endtask

    task automatic rd_chk(input logic [AW-1:0] adr, input logic [DW-1:0] exp, input string req);
        logic [DW-1:0] got;
        bus(1'b0, adr, '0, got);
        check(got === exp, req, got, exp);
    endtask

    task automatic t_reset;
        check((pad_oe | pad_ie | pad_pu | pad_pd | pad_o) === '0, "R1 pads idle", pad_oe, 0);
        rd_chk(0, 32'h0, "R1 row0 zero");
    endtask

    task automatic t_lanes;
        wr(0, 32'h02010C13);
        check(pad_o[0] && pad_oe[0] && pad_ie[0], "R3 pin0 driven", {pad_o[0],pad_oe[0],pad_ie[0]}, 3'b111);
        check(pad_pu[1] && pad_pd[1] && !pad_oe[1], "R2 pin1 pulls", {pad_pu[1],pad_pd[1],pad_oe[1]}, 3'b110);
        check(pad_oe[2] && !pad_o[2], "R3 pin2 drives low", {pad_oe[2],pad_o[2]}, 2'b10);
        check(pad_ie[3] && !pad_oe[3], "R2 pin3 input", {pad_ie[3],pad_oe[3]}, 2'b10);
        rd_chk(0, 32'h02010C13, "R2 readback lanes");
    endtask

    task automatic t_rows;
        wr(1, 32'h11111111);
        check(pad_o[7:4] === 4'hF && pad_oe[7:4] === 4'hF, "R2 row1 pins", {pad_o[7:4],pad_oe[7:4]}, 8'hFF);
        check(pad_o[0] === 1'b1, "R10 row0 untouched", pad_o[0], 1);
        wr(0, 32'h00000001);
        check(pad_o[0] === 1'b0 && pad_pu[1] === 1'b0 && pad_oe[2] === 1'b0, "R10 whole row replaced",
              {pad_o[0],pad_pu[1],pad_oe[2]}, 0);
        check(pad_o[7:4] === 4'hF, "R10 row1 kept", pad_o[7:4], 4'hF);
    endtask

    task automatic t_io_ignore;
        wr(0, 32'h00000011);
        check(pad_o[0] === 1'b1, "R3 pin0 high", pad_o[0], 1);
        wr(0, 32'h00000000);
        check(pad_oe[0] === 1'b0, "R3 oe cleared", pad_oe[0], 0);
        check(pad_o[0] === 1'b1, "R5 io write ignored", pad_o[0], 1);
    endtask

    task automatic t_input;
        @(negedge clk);
        pad_i[0] = 1'b1; pad_i[8] = 1'b1;
        repeat (3) @(posedge clk);
        rd_chk(0, 32'h00000010, "R6 input seen on row0");
        rd_chk(2, 32'h00000010, "R6 input seen on row2");
        rd_chk(1, 32'h11111111, "R6 output bit returned");
        @(negedge clk);
        pad_i = '0;
        repeat (3) @(posedge clk);
        rd_chk(0, 32'h00000000, "R6 input cleared");
    endtask

    task automatic t_banks;
        @(negedge clk);
        per_o[12] = 1; per_oe[12] = 1; per_ie[12] = 1;
        wr(3, 32'h00000024);
        check({pad_o[12],pad_oe[12],pad_ie[12],pad_pu[12]} === 4'hF, "R4 bank1 drives", {pad_o[12],pad_oe[12],pad_ie[12],pad_pu[12]}, 4'hF);
        @(negedge clk);
        pad_i[12] = 1;
        #0.1;
        check({per_i[2*N+12],per_i[N+12],per_i[12]} === 3'b001, "R4 bank1 input", {per_i[2*N+12],per_i[N+12],per_i[12]}, 3'b001);
        wr(3, 32'h00000060);
        check(pad_oe[12] === 1'b0 && pad_pu[12] === 1'b0, "R4 bank3 idle port", {pad_oe[12],pad_pu[12]}, 0);
        @(negedge clk);
        per_oe[2*N+12] = 1; per_o[2*N+12] = 0;
        #0.1;
        check(pad_oe[12] === 1'b1 && pad_o[12] === 1'b0, "R4 bank3 drives", {pad_oe[12],pad_o[12]}, 2'b10);
        check({per_i[2*N+12],per_i[N+12],per_i[12]} === 3'b100, "R4 bank3 input", {per_i[2*N+12],per_i[N+12],per_i[12]}, 3'b100);
    endtask

    task automatic t_park;
        @(negedge clk);
        per_o = '1; per_oe = '1; per_ie = '1;
        wr(3, 32'h000000A8);
        check({pad_o[12],pad_oe[12],pad_ie[12]} === 3'b000, "R9 parked pin off", {pad_o[12],pad_oe[12],pad_ie[12]}, 0);
        check(pad_pd[12] === 1'b1, "R9 pull kept", pad_pd[12], 1);
        check({per_i[2*N+12],per_i[N+12],per_i[12]} === 3'b000, "R9 no owner", {per_i[2*N+12],per_i[N+12],per_i[12]}, 0);
        @(negedge clk);
        per_o = '0; per_oe = '0; per_ie = '0; pad_i = '0;
    endtask

    task automatic t_oor;
        logic [N-1:0] oe_before, o_before;
        oe_before = pad_oe; o_before = pad_o;
        wr(5, 32'hFFFFFFFF);
        wr(4, 32'hFFFFFFFF);
        check(pad_oe === oe_before && pad_o === o_before, "R7 pads unchanged", pad_oe, oe_before);
        rd_chk(5, 32'h0, "R7 row5 reads zero");
        rd_chk(0, 32'h0, "R7 row0 not aliased");
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lanes();
        t_rows();
        t_io_ignore();
        t_input();
        t_banks();
        t_park();
        t_oor();
        done = 1;
        finish_run();
    end
endmodule